// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer

This block sits between a source of external memory accesses and the address pins of a multiplexed-address DRAM port. For each accepted 32-bit access address it decides whether the access can stay in the currently open page as a single column cycle, or whether it must open a new page with a row cycle first. It then drives the address pins for each phase: the full address during the row phase, and a column address during the column phase, aligned according to a code chosen by the memory system.

Two configuration codes arrive with each request. A 4-bit page code selects how many upper address bits are compared against the recorded page. A 3-bit alignment code selects how the column address is placed on the pins. Both codes are taken only when a row cycle starts and stay in force for every page-mode access that follows, until the next row cycle. One page code value turns page mode off completely. Requests use a valid/ready handshake. The row and column strobes are one-cycle phase indicators, and the column phase marks the end of an access.

Top module: `dram_addr_seq`

## Requirements
- R1: After reset `req_ready` is 1, `row_stb` and `col_stb` are 0, `addr_pins` is 0, and the first accepted access always begins with a row phase.
- R2: A row phase lasts one cycle and drives the full access address on `addr_pins`. The column phase follows in the next cycle. `req_ready` returns to 1 in the cycle after the column phase.
- R3: When an access matches the recorded page in every compared bit, no row phase is issued. The column phase appears in the cycle after acceptance.
- R4: Latched page codes 0000, 0001, 0010, 0011 and 0100 compare address bits 31 down to bit 6, 7, 8, 9 and 10 respectively. A difference in any compared bit forces a row phase.
- R5: Latched page codes 1001 to 1111 compare bits 31 down to bit 11 to 17, in code order. Codes 0101, 0110 and 0111 compare bits 31 down to bit 18, 19 and 20.
- R6: While the latched page code is 1000, every access begins with a row phase, even when it repeats the previous address.
- R7: With latched alignment code 000 the column phase drives the address unchanged.
- R8: With a latched alignment code k from 1 to 7, column pin p carries address bit p-(7+k) for p >= 7+k. Pins 2:0 carry address bits 2:0, and the pins between 3 and 6+k drive 0.
- R9: The page and alignment codes are captured only when a row phase is started. Their input values on an access that hits the page have no effect on that access or on later compares.
- R10: The recorded page is replaced by the address of every accepted access, so the following access is compared against the most recent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Byte address of the access |
| page_code | input | 4 | Page compare width code, taken at row start |
| align_code | input | 3 | Column alignment code, taken at row start |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| row_stb | output | 1 | Row phase in progress |
| col_stb | output | 1 | Column phase in progress, last cycle of an access |
| addr_pins | output | 32 | Address driven for the current phase, 0 when idle |

## Verification
An access is accepted at a rising edge. On a page miss the row phase is visible in the following cycle and the column phase one cycle later. On a page hit the column phase is visible in the cycle right after acceptance. The driver records the accepting cycle number with each expected phase it queues. The monitor samples on the falling edge, pops one entry per strobe and compares the phase kind, the pin value and the cycle number. A late, early, missing or extra phase is therefore reported as a miscompare.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ROW  = 2'd1,
    SEQ_COL  = 2'd2
  } seq_state_e;

  localparam logic [3:0] PAGE_OFF_CODE = 4'b1000;
  localparam int unsigned COL_SHIFT_BASE = 7;
  localparam int unsigned COL_KEEP_LOW   = 3;

  // lowest compared address bit for a page code
  function automatic logic [5:0] page_lsb(input logic [3:0] code);
    logic [5:0] lsb;
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4: lsb = 6'd6 + {2'b00, code};
      4'd5, 4'd6, 4'd7:             lsb = 6'd13 + {2'b00, code};
      4'd8:                         lsb = 6'd0;
      default:                      lsb = 6'd2 + {2'b00, code};
    endcase
    return lsb;
  endfunction

endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dram_page_match.sv
module dram_page_match
  import dram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PCODE_W = 4
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [ADDR_W-1:0]  last_addr,
  input  logic               last_vld,
  input  logic [PCODE_W-1:0] code,
  output logic               hit
);
  logic [5:0]        lsb;
  logic [ADDR_W-1:0] diff;

  assign lsb = page_lsb(code);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
    localparam logic [5:0] BIT_IDX = 6'(i);
    assign diff[i] = (cur_addr[i] ^ last_addr[i]) & (BIT_IDX >= lsb);
  end

  assign hit = last_vld && (code != PAGE_OFF_CODE) && (diff == '0);
endmodule

// File: rtl/dram_col_map.sv
module dram_col_map
  import dram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ACODE_W = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ACODE_W-1:0] code,
  output logic [ADDR_W-1:0]  col_addr
);
  localparam int unsigned NCODES = 1 << ACODE_W;

  logic [ADDR_W-1:0] cand [NCODES];

  assign cand[0] = addr;

  for (genvar k = 1; k < NCODES; k++) begin : g_align
    localparam int unsigned SH = COL_SHIFT_BASE + k;
    assign cand[k] = {addr[ADDR_W-1-SH:0], {SH{1'b0}}}
                   | {{(ADDR_W-COL_KEEP_LOW){1'b0}}, addr[COL_KEEP_LOW-1:0]};
  end

  assign col_addr = cand[code];
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PCODE_W = 4,
  parameter int unsigned ACODE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [PCODE_W-1:0] page_code,
  input  logic [ACODE_W-1:0] align_code,
  output logic               req_ready,
  output logic               row_stb,
  output logic               col_stb,
  output logic [ADDR_W-1:0]  addr_pins
);
  logic rst_sync_n;

  seq_state_e         state_q, state_d;
  logic [ADDR_W-1:0]  addr_q, last_q;
  logic               last_vld_q;
  logic [PCODE_W-1:0] pcode_q;
  logic [ACODE_W-1:0] acode_q;
  logic               accept, page_hit, row_start;
  logic [ADDR_W-1:0]  col_addr;

  dram_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dram_page_match #(.ADDR_W(ADDR_W), .PCODE_W(PCODE_W)) i_page_match (
    .cur_addr  (req_addr),
    .last_addr (last_q),
    .last_vld  (last_vld_q),
    .code      (pcode_q),
    .hit       (page_hit)
  );

  dram_col_map #(.ADDR_W(ADDR_W), .ACODE_W(ACODE_W)) i_col_map (
    .addr     (addr_q),
    .code     (acode_q),
    .col_addr (col_addr)
  );

  assign req_ready = (state_q == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign row_start = accept && !page_hit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (accept) state_d = page_hit ? SEQ_COL : SEQ_ROW;
      SEQ_ROW:  state_d = SEQ_COL;
      SEQ_COL:  state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= SEQ_IDLE;
    else             state_q <= state_d;
  end

  // access address and recorded page, enabled on every acceptance
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q     <= '0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
    end else if (accept) begin
      addr_q     <= req_addr;
      last_q     <= req_addr;
      last_vld_q <= 1'b1;
    end
  end

  // configuration captured only when a row cycle opens
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pcode_q <= '0;
      acode_q <= '0;
    end else if (row_start) begin
      pcode_q <= page_code;
      acode_q <= align_code;
    end
  end

  assign row_stb   = (state_q == SEQ_ROW);
  assign col_stb   = (state_q == SEQ_COL);
  assign addr_pins = row_stb ? addr_q : (col_stb ? col_addr : '0);

  AST_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && !last_vld_q) |=> row_stb); // R1

  AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    row_stb |=> (col_stb && !row_stb)); // R2

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(row_stb && col_stb)); // R2

  AST_ROW_FULL_ADDR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    row_stb |-> (addr_pins == addr_q)); // R2

  AST_NO_PAGE_MODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && pcode_q == PAGE_OFF_CODE) |=> row_stb); // R6

  AST_COL_LOW_PINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_stb && acode_q != '0) |-> (addr_pins[2:0] == addr_q[2:0])); // R8

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_stb && !$past(row_stb)) |-> ($stable(acode_q) && $stable(pcode_q))); // R9

  AST_LAST_TRACKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> (last_q == $past(req_addr))); // R10
endmodule

// File: tb/test_dram_addr_seq.sv
module test_dram_addr_seq;
  typedef struct {
    bit          is_row;
    logic [31:0] a;
    int          due;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [3:0]  page_code;
  logic [2:0]  align_code;
  logic        req_ready, row_stb, col_stb;
  logic [31:0] addr_pins;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0, cyc = 0;
  bit   mon_on = 1'b0, done = 1'b0;

  bit          m_vld = 1'b0;
  logic [31:0] m_last = '0;
  logic [3:0]  m_pc = '0;
  logic [2:0]  m_ac = '0;

  dram_addr_seq i_dram_addr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .page_code(page_code), .align_code(align_code), .req_ready(req_ready),
    .row_stb(row_stb), .col_stb(col_stb), .addr_pins(addr_pins)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int low_bit(input logic [3:0] c);
    case (c)
      4'd0: return 6;   4'd1: return 7;   4'd2: return 8;   4'd3: return 9;
      4'd4: return 10;  4'd5: return 18;  4'd6: return 19;  4'd7: return 20;
      4'd8: return 0;   4'd9: return 11;  4'd10: return 12; 4'd11: return 13;
      4'd12: return 14; 4'd13: return 15; 4'd14: return 16; default: return 17;
    endcase
  endfunction

  function automatic logic [31:0] col_of(input logic [31:0] a, input logic [2:0] k);
    if (k == 3'd0) return a;
    return (a << (7 + int'(k))) | (a & 32'h7);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [3:0] pc,
                        input logic [2:0] ac, input string tag);
    bit hit;
    int lb;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    lb  = low_bit(m_pc);
    hit = m_vld && (m_pc != 4'd8) && (((a ^ m_last) >> lb) == 32'd0);
    if (!hit) begin
      m_pc = pc;
      m_ac = ac;
      exp_q.push_back('{1'b1, a, cyc + 1, tag});
      exp_q.push_back('{1'b0, col_of(a, m_ac), cyc + 2, tag});
    end else begin
      exp_q.push_back('{1'b0, col_of(a, m_ac), cyc + 1, tag});
    end
    m_last = a;
    m_vld  = 1'b1;
    req_valid  = 1'b1;
    req_addr   = a;
    page_code  = pc;
    align_code = ac;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  // monitor: pop one expected phase per strobe
  always @(negedge clk) begin
    if (mon_on && (row_stb || col_stb)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected phase", addr_pins, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(row_stb == e.is_row && col_stb == !e.is_row,
              {e.tag, " phase kind"}, {31'd0, row_stb}, {31'd0, e.is_row});
        check(addr_pins == e.a, {e.tag, " pins"}, addr_pins, e.a);
        check(cyc == e.due, {e.tag, " cycle"}, cyc, e.due);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; page_code = '0; align_code = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", {31'd0, req_ready}, 32'd1);
    check(row_stb == 1'b0 && col_stb == 1'b0, "R1 reset strobes",
          {30'd0, row_stb, col_stb}, 32'd0);
    check(addr_pins == 32'd0, "R1 reset pins", addr_pins, 32'd0);
    mon_on = 1'b1;

    access(32'h1234_5640, 4'h0, 3'd0, "R1 first row");
    access(32'h1234_5648, 4'h3, 3'd5, "R3 R7 R9 hit keeps config");
    access(32'h1234_5680, 4'h1, 3'd0, "R4 bit7 miss");
    access(32'h1234_56C0, 4'h2, 3'd0, "R4 bit6 ignored");
    access(32'h0ABC_0000, 4'h5, 3'd1, "R2 new row");
    access(32'h0ABE_0010, 4'h0, 3'd0, "R5 R8 bit17 ignored shift8");
    access(32'h0AB8_0000, 4'hF, 3'd7, "R5 bit18 miss");
    access(32'h0AB9_FFFD, 4'h8, 3'd0, "R5 R8 R10 hit shift14");
    access(32'h0AA0_0000, 4'h8, 3'd4, "R10 miss latch off");
    access(32'h0AA0_0000, 4'h8, 3'd2, "R6 repeat row");
    access(32'h0AA0_0000, 4'h0, 3'd6, "R6 repeat row again");
    access(32'h0000_1000, 4'h9, 3'd3, "R5 row code9");
    access(32'h0000_17FF, 4'h0, 3'd0, "R5 R8 hit code9 shift10");
    access(32'h0000_1800, 4'h4, 3'd2, "R5 bit11 miss");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all phases seen", exp_q.size(), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule